// File: doc/BRIEF.md
# Keyboard and Display Device Register Block

This block lets a 16-bit processor talk to a keyboard and a character display through ordinary loads and stores. Four fixed addresses on a simple synchronous bus hold a status word and a data word for each side. Software polls the top bit of a status word, then moves one character through the matching data word.

On the keyboard side, a one-cycle strobe from the keyboard delivers an 8-bit character. The block latches it and raises the keyboard ready flag. While that flag is up, the keyboard is locked and any further strobes are refused. A processor read of the keyboard data word returns the character, drops the flag and unlocks the keyboard. On the display side, a processor store to the display data word hands the character to the display with a one-cycle valid strobe and marks the display busy. The display reports completion on a done input, and that makes it ready again.

Read data is registered and appears on the bus one cycle after the read strobe. When no read is under way, the bus data reads zero.

Top module: `kbd_disp_regs`

## Requirements
- R1: Reset is synchronous and active low. Afterwards the keyboard ready flag is 0, the display ready flag is 1, disp_valid is 0 and bus_rdata is 0.
- R2: A key_strobe while the keyboard ready flag is 0 stores key_char. A read of 0xF400 then returns 0x8000, and a read of 0xF401 returns the character in bits 7:0.
- R3: A key_strobe while the keyboard ready flag is 1 is refused, and the stored character stays the same.
- R4: A read of 0xF401 clears the keyboard ready flag, so the next key_strobe is accepted.
- R5: A write to 0xF3FF while the display is ready does three things. In the next cycle, disp_valid is 1 for exactly one cycle and disp_char carries bus_wdata[7:0]. The display ready flag (bit 15 of 0xF3FC) reads 0. A read of 0xF3FF returns the character.
- R6: disp_done while the display ready flag is 0 sets the flag. disp_done while the flag is 1 has no effect.
- R7: A write to 0xF3FF while the display is busy is dropped: there is no disp_valid pulse and disp_char keeps its value.
- R8: Bits 14:0 of both status words and bits 15:8 of both data words read as 0. Writes to 0xF400, 0xF401 and 0xF3FC are ignored.
- R9: A read from any other address returns 0 and leaves the keyboard ready flag unchanged.
- R10: bus_rdata carries the addressed word in the cycle after bus_rd is sampled high, and is 0 in every cycle that follows a cycle without bus_rd.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 16 | Word address from the processor |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| key_strobe | input | 1 | One-cycle keystroke strobe from the keyboard |
| key_char | input | 8 | Character that goes with key_strobe |
| disp_char | output | 8 | Character handed to the display |
| disp_valid | output | 1 | One-cycle strobe marking disp_char as new |
| disp_done | input | 1 | Display has finished the last character |

## Verification
Every result in this block is due exactly one clock edge after the stimulus that causes it. Read data, the disp_valid pulse and changes of either ready flag all settle one edge after the strobe is sampled. The bench drives every strobe on a falling edge and samples the outputs on the next falling edge, so each check falls half a period after the edge that produced the result. Flag changes are observed through a status read issued after the triggering strobe has been removed. That read's data is checked one edge later still.

// File: rtl/kd_pkg.sv
// Package: shared address defaults and select type for the keyboard/display
// register block. Assumes a 16-bit word-addressed bus.
package kd_pkg;
    localparam logic [15:0] KBD_STAT_ADDR = 16'hF400;
    localparam logic [15:0] KBD_DATA_ADDR = 16'hF401;
    localparam logic [15:0] DSP_STAT_ADDR = 16'hF3FC;
    localparam logic [15:0] DSP_DATA_ADDR = 16'hF3FF;

    typedef struct packed {
        logic kbd_stat;
        logic kbd_data;
        logic dsp_stat;
        logic dsp_data;
    } kd_sel_t;
endpackage

// File: rtl/kd_decode.sv
// Module: address decoder. Turns a bus address into a one-hot-or-zero select.
// Assumes the four addresses differ; an unmatched address selects nothing.
module kd_decode
    import kd_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter logic [ADDR_W-1:0] A_KSTAT = KBD_STAT_ADDR,
    parameter logic [ADDR_W-1:0] A_KDATA = KBD_DATA_ADDR,
    parameter logic [ADDR_W-1:0] A_DSTAT = DSP_STAT_ADDR,
    parameter logic [ADDR_W-1:0] A_DDATA = DSP_DATA_ADDR
) (
    input  logic [ADDR_W-1:0] addr,
    output kd_sel_t           sel
);
    // Compare the address against each register location.
    always_comb begin
        sel.kbd_stat = (addr == A_KSTAT);
        sel.kbd_data = (addr == A_KDATA);
        sel.dsp_stat = (addr == A_DSTAT);
        sel.dsp_data = (addr == A_DDATA);
    end
endmodule

// File: rtl/kd_kbd_port.sv
// Module: keyboard side. Latches a keystroke when unlocked, raises ready,
// refuses keystrokes while ready is set, and unlocks on a data-word read.
// Assumes key_strobe lasts one cycle per keystroke.
module kd_kbd_port #(
    parameter int CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              key_strobe,
    input  logic [CHAR_W-1:0] key_char,
    input  logic              take,
    output logic              ready,
    output logic [CHAR_W-1:0] char_q
);
    // Ready flag and character holding register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ready  <= 1'b0;
            char_q <= '0;
        end else if (ready) begin
            if (take) ready <= 1'b0;
        end else if (key_strobe) begin
            ready  <= 1'b1;
            char_q <= key_char;
        end
    end

    // R3: a keystroke while locked leaves the character untouched.
    assert_refuse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && key_strobe) |=> (char_q == $past(char_q)));
    // R4: a data-word read while ready drops the flag.
    assert_take_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && take) |=> !ready);
    // R2: an accepted keystroke raises the flag.
    assert_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready && key_strobe) |=> (ready && char_q == $past(key_char)));
endmodule

// File: rtl/kd_disp_port.sv
// Module: display side. Accepts one character while ready, pulses valid for
// one cycle, stays busy until the display reports done. Writes while busy are
// dropped. Assumes disp_done is meaningful only while busy.
module kd_disp_port #(
    parameter int CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              put,
    input  logic [CHAR_W-1:0] put_char,
    input  logic              done,
    output logic              ready,
    output logic              valid,
    output logic [CHAR_W-1:0] char_q
);
    // Busy/ready state, outgoing character and valid strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ready  <= 1'b1;
            valid  <= 1'b0;
            char_q <= '0;
        end else begin
            valid <= 1'b0;
            if (ready) begin
                if (put) begin
                    char_q <= put_char;
                    valid  <= 1'b1;
                    ready  <= 1'b0;
                end
            end else if (done) begin
                ready <= 1'b1;
            end
        end
    end

    // R5: the valid strobe lasts exactly one cycle.
    assert_valid_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> !valid);
    // R5: while the strobe is out the display reads busy.
    assert_busy_with_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> !ready);
    // R6: done while busy restores ready.
    assert_done_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready && done) |=> ready);
    // R7: a write while busy leaves the character unchanged.
    assert_busy_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready && put) |=> (!valid && char_q == $past(char_q)));
endmodule

// File: rtl/kbd_disp_regs.sv
// Module: top of the keyboard/display device register block. Decodes the
// bus, routes strobes to both ports and returns registered read data.
// Assumes bus_rd/bus_wr are single-cycle per access; read data follows one
// cycle after the read strobe and is zero otherwise.
module kbd_disp_regs
    import kd_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16,
    parameter int CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              key_strobe,
    input  logic [CHAR_W-1:0] key_char,
    output logic [CHAR_W-1:0] disp_char,
    output logic              disp_valid,
    input  logic              disp_done
);
    localparam int FLAG_BIT = DATA_W - 1;
    localparam int PAD_W    = DATA_W - CHAR_W;

    kd_sel_t            sel;
    logic               kbd_ready;
    logic [CHAR_W-1:0]  kbd_char;
    logic               dsp_ready;
    logic [DATA_W-1:0]  rd_word;

    kd_decode #(
        .ADDR_W (ADDR_W),
        .A_KSTAT(ADDR_W'(KBD_STAT_ADDR)),
        .A_KDATA(ADDR_W'(KBD_DATA_ADDR)),
        .A_DSTAT(ADDR_W'(DSP_STAT_ADDR)),
        .A_DDATA(ADDR_W'(DSP_DATA_ADDR))
    ) u_dec (
        .addr(bus_addr),
        .sel (sel)
    );

    kd_kbd_port #(.CHAR_W(CHAR_W)) u_kbd (
        .clk       (clk),
        .rst_n     (rst_n),
        .key_strobe(key_strobe),
        .key_char  (key_char),
        .take      (bus_rd && sel.kbd_data),
        .ready     (kbd_ready),
        .char_q    (kbd_char)
    );

    kd_disp_port #(.CHAR_W(CHAR_W)) u_dsp (
        .clk     (clk),
        .rst_n   (rst_n),
        .put     (bus_wr && sel.dsp_data),
        .put_char(bus_wdata[CHAR_W-1:0]),
        .done    (disp_done),
        .ready   (dsp_ready),
        .valid   (disp_valid),
        .char_q  (disp_char)
    );

    // Select the word seen by a read; unmapped addresses give zero.
    always_comb begin
        rd_word = '0;
        unique case (1'b1)
            sel.kbd_stat: rd_word[FLAG_BIT] = kbd_ready;
            sel.kbd_data: rd_word = {{PAD_W{1'b0}}, kbd_char};
            sel.dsp_stat: rd_word[FLAG_BIT] = dsp_ready;
            sel.dsp_data: rd_word = {{PAD_W{1'b0}}, disp_char};
            default:      rd_word = '0;
        endcase
    end

    // Register read data; zero in cycles without a read.
    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_word;
        else             bus_rdata <= '0;
    end

    // R10: no read strobe means zero data next cycle.
    assert_idle_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> (bus_rdata == '0));
    // R8: reserved middle bits of every returned word are zero.
    assert_reserved_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[FLAG_BIT-1:CHAR_W] == '0);
    // R9: a read of an unmapped address returns zero.
    assert_unmapped_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !(|sel)) |=> (bus_rdata == '0));
endmodule

// File: tb/kbd_disp_regs_test.sv
`timescale 1ns/1ps
module kbd_disp_regs_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] bus_addr;
    logic        bus_rd, bus_wr;
    logic [15:0] bus_wdata;
    logic [15:0] bus_rdata;
    logic        key_strobe;
    logic [7:0]  key_char;
    logic [7:0]  disp_char;
    logic        disp_valid;
    logic        disp_done;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    kbd_disp_regs uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .key_strobe(key_strobe), .key_char(key_char), .disp_char(disp_char),
        .disp_valid(disp_valid), .disp_done(disp_done)
    );

    // op: 1 read+check, 2 write, 3 keystroke, 4 display done
    localparam int NV = 12;
    localparam logic [35:0] VEC [NV] = '{
        36'h1_F400_0000,  // R1 kbd not ready
        36'h1_F3FC_8000,  // R1 display ready
        36'h3_0000_0041,  // key 'A'
        36'h1_F400_8000,  // R2 ready set
        36'h3_0000_0042,  // R3 refused
        36'h1_F401_0041,  // R3 R4 original char, clears flag
        36'h1_F400_0000,  // R4 flag cleared
        36'h3_0000_0043,  // R4 accepted after unlock
        36'h1_F401_0043,  // R4 new char
        36'h2_F400_8000,  // R8 write to kbd status
        36'h1_F400_0000,  // R8 ignored
        36'h1_F3FE_0000   // R9 unmapped
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [15:0] a, input logic [15:0] exp, input string req);
        @(negedge clk); bus_addr = a; bus_rd = 1'b1;
        @(negedge clk); bus_rd = 1'b0;
        check(req, bus_rdata, exp);
    endtask

    task automatic wr(input logic [15:0] a, input logic [15:0] d);
        @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic key(input logic [7:0] c);
        @(negedge clk); key_char = c; key_strobe = 1'b1;
        @(negedge clk); key_strobe = 1'b0;
    endtask

    task automatic done_pulse();
        @(negedge clk); disp_done = 1'b1;
        @(negedge clk); disp_done = 1'b0;
    endtask

    initial begin
        rst_n = 1'b0; bus_addr = '0; bus_rd = 0; bus_wr = 0; bus_wdata = '0;
        key_strobe = 0; key_char = '0; disp_done = 0;
        repeat (3) @(negedge clk);
        check("R1 disp_valid", {15'd0, disp_valid}, 16'h0);
        check("R1 rdata", bus_rdata, 16'h0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            case (VEC[i][35:32])
                4'h1: rd(VEC[i][31:16], VEC[i][15:0], $sformatf("R1-R9 vector %0d", i));
                4'h2: wr(VEC[i][31:16], VEC[i][15:0]);
                4'h3: key(VEC[i][7:0]);
                default: done_pulse();
            endcase
        end

        // R5: display write, pulse, busy, readback
        @(negedge clk); bus_addr = 16'hF3FF; bus_wdata = 16'h1234; bus_wr = 1'b1;
        @(negedge clk); bus_wr = 1'b0;
        check("R5 valid high", {15'd0, disp_valid}, 16'h1);
        check("R5 char", {8'd0, disp_char}, 16'h0034);
        @(negedge clk);
        check("R5 valid one cycle", {15'd0, disp_valid}, 16'h0);
        rd(16'hF3FC, 16'h0000, "R5 busy");
        rd(16'hF3FF, 16'h0034, "R5 readback");

        // R7: write while busy is dropped
        @(negedge clk); bus_addr = 16'hF3FF; bus_wdata = 16'h0055; bus_wr = 1'b1;
        @(negedge clk); bus_wr = 1'b0;
        check("R7 no pulse", {15'd0, disp_valid}, 16'h0);
        check("R7 char kept", {8'd0, disp_char}, 16'h0034);

        // R6: done restores ready; done while ready has no effect
        done_pulse();
        rd(16'hF3FC, 16'h8000, "R6 ready after done");
        @(negedge clk); disp_done = 1'b1;
        @(negedge clk); disp_done = 1'b0;
        check("R6 no pulse on idle done", {15'd0, disp_valid}, 16'h0);
        rd(16'hF3FC, 16'h8000, "R6 still ready");

        // R8: write to display status ignored
        wr(16'hF3FC, 16'h0000);
        rd(16'hF3FC, 16'h8000, "R8 dsp status write ignored");

        // R9: unmapped read leaves keyboard flag set
        key(8'h7A);
        rd(16'hF402, 16'h0000, "R9 unmapped zero");
        rd(16'hF400, 16'h8000, "R9 flag kept");
        // R8: write to kbd data ignored
        wr(16'hF401, 16'h0011);
        rd(16'hF401, 16'h007A, "R8 kbd data write ignored");

        // R10: idle cycle gives zero
        @(negedge clk);
        check("R10 idle zero", bus_rdata, 16'h0000);

        // R1: reset mid-operation
        key(8'h61);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        rd(16'hF400, 16'h0000, "R1 kbd flag after reset");
        rd(16'hF3FC, 16'h8000, "R1 dsp flag after reset");

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule